// File: doc/BRIEF.md
# Stop-Clock Power State Controller

This block puts a processor core into a low-power stopped state and brings it back out. An external agent pulls an active-low stop request that may change at any time relative to the bus clock. The block synchronises it, then sends one acknowledge message over a request/grant handshake to the bus-transaction logic. Only after that message is granted does it drop the clock enables of the core execution domains.

While stopped, the bus-interface domain and the interrupt-controller domain keep their enables high. Snooping and interrupt service therefore continue. When the request is released, the block spends one cycle in a restart state with every enable high, then returns to the running state and pulses a resume indication for one cycle. The request never touches the bus clock itself. The block only drives per-domain enable bits that real gating cells elsewhere act on.

Top module: `stopclk_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, `pwr_state` reads 0 (run), every `clk_en` bit is 1, and `ack_req` and `resume_pulse` are 0. The state codes are 0 run, 1 acknowledge pending, 2 stopped, 3 restart.
- R2: The stop request passes through a two-stage synchroniser. A low level first sampled at clock edge k moves `pwr_state` from 0 to 1 after edge k+2, and `pwr_state` is still 0 after edges k and k+1.
- R3: In state 1, `ack_req` rises at an edge only when `bus_idle` was high at that edge. It then stays high until sampled together with `ack_gnt`, and it is raised at most once per stop entry.
- R4: All enables stay high until the acknowledge is granted. At the edge where `ack_req` and `ack_gnt` are both high with the request still active, the state becomes 2 and `clk_en` equals the keep mask (bit 0 bus interface, bit 1 interrupt controller; 6'b000011 with the default six domains).
- R5: The bus-interface and interrupt-controller enable bits are never low.
- R6: In state 2, a high stop request first sampled at edge k gives state 3 after edge k+2, with every enable bit high.
- R7: State 3 lasts exactly one cycle and is followed by state 0. `resume_pulse` is high for exactly that first run cycle.
- R8: If the request is released while in state 1, the acknowledge is still held until granted. The grant edge then moves the block straight to state 3, never entering state 2.
- R9: `ack_gnt` while `ack_req` is low has no effect on state or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| bus_idle | input | 1 | Bus free to accept the acknowledge message |
| ack_gnt | input | 1 | Grant for the acknowledge message |
| ack_req | output | 1 | Acknowledge message request |
| clk_en | output | N_DOM | Per-domain clock enables |
| pwr_state | output | 2 | Current power state code |
| resume_pulse | output | 1 | One-cycle execution-resume indication |

## Verification
The bench targets three corner cases.

The first is the exact synchroniser latency on entry and exit. A design with one stage too few or too many moves the state a cycle early or late.

The second is the handshake edges. A grant arriving before the request or while running must be ignored. A busy bus must hold off the request. Once granted, the request must not come back. A design that gated early or re-requested would show the wrong enable mask or a second request.

The third is a release during the pending acknowledge. A design that dropped the request or passed through the stopped state would gate the core for a cycle it should not.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;

  typedef enum logic [1:0] {
    PS_RUN     = 2'd0,
    PS_ACK     = 2'd1,
    PS_STOP    = 2'd2,
    PS_RESTART = 2'd3
  } pstate_e;

  // Mask of domains whose enable is never dropped.
  function automatic logic [31:0] keep_mask(input int biu_idx, input int irq_idx);
    return (32'd1 << biu_idx) | (32'd1 << irq_idx);
  endfunction

  // Whether a gated domain is enabled in a given state.
  function automatic logic core_enabled(input pstate_e st);
    return st != PS_STOP;
  endfunction

  // Next-state rule of the power sequencer.
  function automatic pstate_e next_pstate(input pstate_e cur, input logic stop_act,
                                          input logic ack_fire);
    pstate_e nx;
    nx = cur;
    case (cur)
      PS_RUN:     if (stop_act) nx = PS_ACK;
      PS_ACK:     if (ack_fire) nx = stop_act ? PS_STOP : PS_RESTART;
      PS_STOP:    if (!stop_act) nx = PS_RESTART;
      PS_RESTART: nx = PS_RUN;
      default:    nx = PS_RUN;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/stopclk_sync.sv
module stopclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= async_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/stopclk_fsm.sv
module stopclk_fsm
  import stopclk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    stop_act,
  input  logic    bus_idle,
  input  logic    ack_gnt,
  output pstate_e state,
  output logic    ack_req,
  output logic    ack_fire,
  output logic    resume_pulse
);
  pstate_e state_nx;

  assign ack_fire = ack_req & ack_gnt;
  assign state_nx = next_pstate(state, stop_act, ack_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_RUN;
    else        state <= state_nx;
  end

  // One request per entry: raised on an idle bus, cleared by the grant,
  // which also leaves the pending state at the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_req <= 1'b0;
    end else if (state == PS_ACK) begin
      if (ack_fire)                 ack_req <= 1'b0;
      else if (!ack_req && bus_idle) ack_req <= 1'b1;
    end else begin
      ack_req <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resume_pulse <= 1'b0;
    else        resume_pulse <= (state == PS_RESTART);
  end
endmodule

// File: rtl/stopclk_gate.sv
module stopclk_gate
  import stopclk_pkg::*;
#(
  parameter int N_DOM   = 6,
  parameter int BIU_IDX = 0,
  parameter int IRQ_IDX = 1
) (
  input  pstate_e          state,
  output logic [N_DOM-1:0] clk_en
);
  localparam logic [31:0]      KEEP32 = keep_mask(BIU_IDX, IRQ_IDX);
  localparam logic [N_DOM-1:0] KEEP   = KEEP32[N_DOM-1:0];

  logic core_on;
  assign core_on = core_enabled(state);

  generate
    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
      if (KEEP[d]) begin : g_keep
        assign clk_en[d] = 1'b1;
      end else begin : g_core
        assign clk_en[d] = core_on;
      end
    end
  endgenerate
endmodule

// File: rtl/stopclk_ctrl.sv
module stopclk_ctrl
  import stopclk_pkg::*;
#(
  parameter int N_DOM       = 6,
  parameter int BIU_IDX     = 0,
  parameter int IRQ_IDX     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req_n,
  input  logic             bus_idle,
  input  logic             ack_gnt,
  output logic             ack_req,
  output logic [N_DOM-1:0] clk_en,
  output logic [1:0]       pwr_state,
  output logic             resume_pulse
);
  logic    stop_sync_n;
  logic    stop_act;
  logic    ack_fire;
  pstate_e state;

  stopclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_n (stop_req_n),
    .sync_n  (stop_sync_n)
  );

  assign stop_act = ~stop_sync_n;

  stopclk_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_act     (stop_act),
    .bus_idle     (bus_idle),
    .ack_gnt      (ack_gnt),
    .state        (state),
    .ack_req      (ack_req),
    .ack_fire     (ack_fire),
    .resume_pulse (resume_pulse)
  );

  stopclk_gate #(.N_DOM(N_DOM), .BIU_IDX(BIU_IDX), .IRQ_IDX(IRQ_IDX)) u_gate (
    .state  (state),
    .clk_en (clk_en)
  );

  assign pwr_state = state;
endmodule

// File: rtl/stopclk_ctrl_chk.sv
module stopclk_ctrl_chk
  import stopclk_pkg::*;
#(
  parameter int N_DOM   = 6,
  parameter int BIU_IDX = 0,
  parameter int IRQ_IDX = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_idle,
  input logic             ack_gnt,
  input logic             ack_req,
  input logic             ack_fire,
  input logic             stop_act,
  input logic [N_DOM-1:0] clk_en,
  input logic [1:0]       pwr_state,
  input logic             resume_pulse
);
  a_r3_req_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req) |-> $past(bus_idle));

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !ack_gnt) |=> ack_req);

  a_r3_req_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> (pwr_state == PS_ACK));

  a_r4_stop_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PS_STOP && $past(pwr_state) != PS_STOP) |-> $past(ack_fire));

  a_r4_gated_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PS_STOP) |-> ($countones(clk_en) == 2));

  a_r5_keep_domains: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en[BIU_IDX] && clk_en[IRQ_IDX]);

  a_r6_all_on_outside_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != PS_STOP) |-> (&clk_en));

  a_r7_restart_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PS_RESTART) |=> (pwr_state == PS_RUN));

  a_r7_resume_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> ($past(pwr_state) == PS_RESTART));

  a_r8_release_skips_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !stop_act) |=> (pwr_state == PS_RESTART));
endmodule

bind stopclk_ctrl stopclk_ctrl_chk #(
  .N_DOM(N_DOM), .BIU_IDX(BIU_IDX), .IRQ_IDX(IRQ_IDX)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_idle     (bus_idle),
  .ack_gnt      (ack_gnt),
  .ack_req      (ack_req),
  .ack_fire     (ack_fire),
  .stop_act     (stop_act),
  .clk_en       (clk_en),
  .pwr_state    (pwr_state),
  .resume_pulse (resume_pulse)
);

// File: tb/stopclk_ctrl_test.sv
module stopclk_ctrl_test;
  localparam logic [5:0] ALL_ON  = 6'b111111;
  localparam logic [5:0] KEEP_ON = 6'b000011;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       stop_req_n;
  logic       bus_idle;
  logic       ack_gnt;
  logic       ack_req;
  logic [5:0] clk_en;
  logic [1:0] pwr_state;
  logic       resume_pulse;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [1:0] st;
    logic [5:0] en;
    logic       req;
    logic       res;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  stopclk_ctrl uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_req_n   (stop_req_n),
    .bus_idle     (bus_idle),
    .ack_gnt      (ack_gnt),
    .ack_req      (ack_req),
    .clk_en       (clk_en),
    .pwr_state    (pwr_state),
    .resume_pulse (resume_pulse)
  );

  // Driver: one clock edge, then record what must be visible after it.
  task automatic step(input logic [1:0] st, input logic req, input logic res,
                      input string tag);
    exp_t e;
    @(posedge clk);
    e.st  = st;
    e.en  = (st == 2'd2) ? KEEP_ON : ALL_ON;
    e.req = req;
    e.res = res;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compares outputs at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (pwr_state !== e.st || clk_en !== e.en || ack_req !== e.req ||
            resume_pulse !== e.res) begin
          errors++;
          $display("FAIL %s: actual st=%0d en=%b req=%b res=%b expected st=%0d en=%b req=%b res=%b",
                   e.tag, pwr_state, clk_en, ack_req, resume_pulse,
                   e.st, e.en, e.req, e.res);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stop_req_n = 1'b1; bus_idle = 1'b1; ack_gnt = 1'b0;
    @(negedge clk);
    step(2'd0, 1'b0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    step(2'd0, 1'b0, 1'b0, "R1 after reset");

    // Entry with a busy bus, stray grants, hold, gating, release.
    bus_idle = 1'b0; stop_req_n = 1'b0;
    step(2'd0, 1'b0, 1'b0, "R2 sync edge 1");
    step(2'd0, 1'b0, 1'b0, "R2 sync edge 2");
    step(2'd1, 1'b0, 1'b0, "R2 enter pending");
    ack_gnt = 1'b1;
    step(2'd1, 1'b0, 1'b0, "R3 busy bus / R9 early grant");
    ack_gnt = 1'b0; bus_idle = 1'b1;
    step(2'd1, 1'b1, 1'b0, "R3 raise on idle");
    step(2'd1, 1'b1, 1'b0, "R3 hold / R4 not gated yet");
    ack_gnt = 1'b1;
    step(2'd2, 1'b0, 1'b0, "R4 gate on grant");
    ack_gnt = 1'b0;
    step(2'd2, 1'b0, 1'b0, "R3 one shot / R5");
    ack_gnt = 1'b1;
    step(2'd2, 1'b0, 1'b0, "R9 grant while stopped");
    ack_gnt = 1'b0; stop_req_n = 1'b1;
    step(2'd2, 1'b0, 1'b0, "R6 sync edge 1");
    step(2'd2, 1'b0, 1'b0, "R6 sync edge 2");
    step(2'd3, 1'b0, 1'b0, "R6 restart all on");
    step(2'd0, 1'b0, 1'b1, "R7 resume pulse");
    step(2'd0, 1'b0, 1'b0, "R7 single pulse");

    // Release while the acknowledge is pending.
    stop_req_n = 1'b0;
    step(2'd0, 1'b0, 1'b0, "R2 sync edge 1b");
    step(2'd0, 1'b0, 1'b0, "R2 sync edge 2b");
    step(2'd1, 1'b0, 1'b0, "R2 enter pending b");
    stop_req_n = 1'b1;
    step(2'd1, 1'b1, 1'b0, "R8 request raised");
    step(2'd1, 1'b1, 1'b0, "R8 held after release");
    step(2'd1, 1'b1, 1'b0, "R8 still held");
    ack_gnt = 1'b1;
    step(2'd3, 1'b0, 1'b0, "R8 straight to restart");
    ack_gnt = 1'b0;
    step(2'd0, 1'b0, 1'b1, "R7 resume after R8");
    step(2'd0, 1'b0, 1'b0, "R7 single pulse b");

    // Grant while running.
    ack_gnt = 1'b1;
    step(2'd0, 1'b0, 1'b0, "R9 grant in run 1");
    step(2'd0, 1'b0, 1'b0, "R9 grant in run 2");
    ack_gnt = 1'b0;
    step(2'd0, 1'b0, 1'b0, "R9 run after grant");

    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule